// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the sample tick for a serial port that oversamples each bit 16 times. The tick comes from a faster reference clock. The ratio between the two clocks is written as a fixed-point divisor. The divisor has a 16-bit whole part and a 6-bit part counted in 64ths. Together they form one combined value: the whole part shifted up by six places, with the fraction in the low six bits. This combined value equals four times the reference frequency divided by the baud rate.

Each tick period is either the whole part or the whole part plus one reference clock long. A 6-bit accumulator adds the fraction on every tick. Each carry out of it stretches the following period by one clock. The extra clocks are therefore spread out over time, and across every run of 64 ticks the elapsed time matches the combined value exactly.

Software loads new divisor values while the port is idle, using a load strobe. The strobe also restarts the period count and the accumulator. An enable input pauses the generator without losing its position.

Top module: `fracbaud_gen`

## Requirements
- R1: After synchronous reset, `tick` is low and the held divisor is zero, so no tick appears until a load, whatever `en` does.
- R2: `div_int` and `div_frac` are captured only in a cycle where `load` is high. Changing them at any other time leaves the tick spacing unchanged.
- R3: With `en` high, the first tick after a load rises exactly I clock edges after the load edge, where I is the loaded whole part.
- R4: Every tick period lasts either I or I+1 clocks. When the fraction is zero, every period is exactly I.
- R5: The accumulator starts at zero on load. Tick k adds the fraction F modulo 64, and a carry out of that addition makes the period after tick k last I+1 clocks. Over any 64 consecutive periods starting at a load, the total is I*64+F clocks.
- R6: When I is at least 2, `tick` is high for exactly one clock per period.
- R7: While `en` is low, no tick is produced and the count is frozen. When `en` returns, the pending tick is delayed by exactly the number of disabled cycles.
- R8: A whole part of zero produces no ticks, whatever the fraction. This includes a combined value of zero.
- R9: A load received during operation restarts both the period count and the accumulator. The tick sequence that follows is the same as after a fresh load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_int | input | 16 | Whole part of the divisor |
| div_frac | input | 6 | Fractional part of the divisor, in 64ths |
| load | input | 1 | Captures the divisor and restarts the generator |
| en | input | 1 | Run enable; low freezes the generator |
| tick | output | 1 | Registered one-clock tick at 16x the baud rate |

## Verification
The bench builds the block with its default widths: a 16-bit whole part and a 6-bit fraction, so a full accumulator cycle is 64 ticks. Small whole parts from 1 to 7 keep each 64-period run short. This makes it practical to check every individual period against the carry pattern, for fractions of 0, 1, 63 and several values in between. One large whole part, 300, confirms that the counter is wide enough beyond 8 bits. Directed cases cover the zero divisor, a zero whole part with a nonzero fraction, pausing mid-period, reloading mid-stream and reset during operation.

// File: rtl/fracbaud_pkg.sv
package fracbaud_pkg;
  localparam int unsigned DEF_INT_W  = 16;
  localparam int unsigned DEF_FRAC_W = 6;
endpackage

// File: rtl/fracbaud_hold.sv
module fracbaud_hold #(
  parameter int unsigned INT_W  = fracbaud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = fracbaud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [INT_W-1:0]  int_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      int_q   <= '0;
      frac_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      int_q   <= int_in;
      frac_q  <= frac_in;
      valid_q <= (int_in != '0);
    end
  end

  AST_HOLD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(int_q) && $stable(frac_q)); // R2
endmodule

// File: rtl/fracbaud_acc.sv
module fracbaud_acc #(
  parameter int unsigned FRAC_W = fracbaud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, frac};
    carry = sum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (advance) acc_q <= sum[FRAC_W-1:0];
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> acc_q == '0); // R9
  AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clear && !advance) |=> $stable(acc_q)); // R5
endmodule

// File: rtl/fracbaud_cnt.sv
module fracbaud_cnt #(
  parameter int unsigned INT_W = fracbaud_pkg::DEF_INT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [INT_W-1:0] load_val,
  input  logic             run,
  input  logic [INT_W-1:0] period_int,
  input  logic             stretch,
  output logic             wrap,
  output logic             tick_q
);
  logic [INT_W-1:0] cnt_q;
  logic [INT_W-1:0] one_w;
  logic [INT_W-1:0] ext_w;

  always_comb begin
    one_w = {{(INT_W-1){1'b0}}, 1'b1};
    ext_w = {{(INT_W-1){1'b0}}, stretch};
    wrap  = run && !load && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val - one_w;
      tick_q <= 1'b0;
    end else if (run) begin
      tick_q <= wrap;
      if (wrap) cnt_q <= period_int - one_w + ext_w;
      else      cnt_q <= cnt_q - one_w;
    end else begin
      tick_q <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (period_int != '0) |-> cnt_q <= period_int); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q)); // R7
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    load |=> !tick_q); // R9
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (tick_q && period_int > one_w) |=> !tick_q); // R6
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen #(
  parameter int unsigned INT_W  = fracbaud_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = fracbaud_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              load,
  input  logic              en,
  output logic              tick
);
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              valid_q;
  logic              run;
  logic              wrap;
  logic              carry;

  assign run = en && valid_q;

  fracbaud_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W)) hold_i (
    .clk(clk), .rst(rst), .load(load), .int_in(div_int), .frac_in(div_frac),
    .int_q(int_q), .frac_q(frac_q), .valid_q(valid_q)
  );

  fracbaud_acc #(.FRAC_W(FRAC_W)) acc_i (
    .clk(clk), .rst(rst), .clear(load), .advance(wrap), .frac(frac_q),
    .carry(carry)
  );

  fracbaud_cnt #(.INT_W(INT_W)) cnt_i (
    .clk(clk), .rst(rst), .load(load), .load_val(div_int), .run(run),
    .period_int(int_q), .stretch(carry), .wrap(wrap), .tick_q(tick)
  );

  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> !tick); // R8
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick); // R7
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !tick); // R1
endmodule

// File: tb/fracbaud_gen_tb.sv
module fracbaud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic        load = 1'b0;
  logic        en = 1'b0;
  logic        tick;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam int NV = 8;
  localparam int VEC_I [NV] = '{1, 1, 2, 3, 5, 4, 7, 2};
  localparam int VEC_F [NV] = '{0, 63, 1, 32, 0, 21, 63, 40};

  always #10 clk = ~clk;

  fracbaud_gen dut_i (.clk(clk), .rst(rst), .div_int(div_int), .div_frac(div_frac),
                      .load(load), .en(en), .tick(tick));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int i, input int f);
    div_int = 16'(i); div_frac = 6'(f); load = 1'b1;
    step();
    load = 1'b0;
  endtask

  task automatic measure(output int n, input int lim);
    n = 0;
    do begin step(); n++; end while (!tick && n < lim);
  endtask

  task automatic quiet(input int cyc, input string req);
    int seen = 0;
    for (int k = 0; k < cyc; k++) begin step(); if (tick) seen++; end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, ba, sum, expn;
    @(negedge clk); step(); step();
    rst = 1'b0;
    chk(tick == 1'b0, "R1 reset tick", tick, 0);
    en = 1'b1;
    quiet(50, "R1 no tick before load");

    for (int v = 0; v < NV; v++) begin
      do_load(VEC_I[v], VEC_F[v]);
      measure(n, 1000);
      chk(n == VEC_I[v], "R3 first tick", n, VEC_I[v]);
      ba = 0; sum = 0;
      for (int k = 0; k < 64; k++) begin
        ba = ba + VEC_F[v];
        expn = VEC_I[v] + (ba >= 64 ? 1 : 0);
        ba = ba % 64;
        measure(n, 1000);
        sum += n;
        chk(n == expn, "R4 R5 period", n, expn);
      end
      chk(sum == VEC_I[v] * 64 + VEC_F[v], "R5 64-period total", sum, VEC_I[v] * 64 + VEC_F[v]);
    end

    do_load(300, 5);
    measure(n, 2000);
    chk(n == 300, "R3 wide first tick", n, 300);
    measure(n, 2000);
    chk(n == 300, "R4 wide period", n, 300);

    do_load(4, 0);
    measure(n, 100);
    step();
    chk(tick == 1'b0, "R6 pulse width", tick, 0);
    div_int = 16'd9;
    measure(n, 100);
    chk(n == 3, "R2 ignore unloaded input", n + 1, 4);
    measure(n, 100);
    chk(n == 4, "R2 ignore unloaded input", n, 4);

    do_load(5, 0);
    measure(n, 100);
    step(); step();
    en = 1'b0;
    quiet(7, "R7 no tick while disabled");
    en = 1'b1;
    measure(n, 100);
    chk(n + 9 == 12, "R7 resume delay", n + 9, 12);

    do_load(3, 32);
    measure(n, 100);
    measure(n, 100);
    chk(n == 3, "R5 alternate short", n, 3);
    do_load(3, 32);
    measure(n, 100);
    chk(n == 3, "R9 reload first", n, 3);
    measure(n, 100);
    chk(n == 3, "R9 accumulator restarted", n, 3);
    measure(n, 100);
    chk(n == 4, "R9 carry period", n, 4);

    do_load(0, 0);
    quiet(200, "R8 zero divisor");
    do_load(0, 17);
    quiet(200, "R8 zero whole part");
    do_load(2, 0);
    measure(n, 100);
    chk(n == 2, "R8 recovery", n, 2);

    do_load(3, 0);
    measure(n, 100);
    rst = 1'b1; step(); rst = 1'b0;
    quiet(50, "R1 reset mid-run");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule